// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave on a two-wire serial bus (clock line plus open-drain data line) that fronts a byte-wide on-chip RAM standing in for a serial EEPROM array. Both bus lines are oversampled on the system clock. The controller finds start, repeated start and stop conditions, decodes a device address against three strap pins, takes a two-byte word address, and then either buffers a page of write data or streams read data out. An internal address counter survives between transactions, so a read that carries no word address continues where the last access ended.

Writes are held in a 64-byte page buffer and reach the array only when a stop is seen. A busy window of `BUSY_CYCLES` system clocks then follows, standing in for the self-timed programming time. During that window the slave does not acknowledge its device address, so a master can poll until the write is finished. A write-protect input turns a write into a no-op: the bytes are still acknowledged, nothing is stored and no busy window starts.

The array holds 2^`ADDR_W` bytes. Set `ADDR_W` to 15 for the full 32,768-byte part. The default of 12 builds a 4,096-byte array that keeps elaboration small. The SDA output is an active-high "pull low" enable for an external open-drain pad.

Top module: `ee2w_slave`

## Requirements
- R1: The slave acknowledges a device address byte only when its upper seven bits equal binary 1010 followed by `strap_i[2]`, `strap_i[1]`, `strap_i[0]`. Bit 0 selects read (1) or write (0). For any other byte it leaves SDA released for the whole transaction.
- R2: A falling SDA while SCL is high is a start. A rising SDA while SCL is high is a stop. A start during a transaction is a repeated start and restarts address decoding. The slave changes its SDA drive only after SCL has gone low, or on a start or stop.
- R3: After a write device address, the next two bytes form the word address, high byte first. Address bits at and above `ADDR_W` are ignored. The word address loads the address counter.
- R4: Data bytes of a write go to successive addresses. Only the low 6 address bits advance, so a write that passes the end of a 64-byte page continues at the start of that same page. Each data byte is acknowledged.
- R5: Buffered data bytes are written to the array when a stop ends the write. For the next `BUSY_CYCLES` clocks the slave does not acknowledge its device address. After that it acknowledges again.
- R6: While `wp_i` is high when the stop arrives, buffered bytes are discarded, the array is unchanged and no busy window starts. Data bytes are still acknowledged.
- R7: A read device address with no preceding word address returns the byte at the address counter. The counter always holds the last accessed address plus one, and it keeps its value across transactions.
- R8: A write of device address plus word address, followed by a repeated start and a read device address, returns data starting at the newly loaded word address.
- R9: When the master acknowledges a read byte, the next byte follows from the next address. A master not-acknowledge ends the read and releases SDA.
- R10: During reads the counter rolls over from the last byte of the array to byte 0.
- R11: After reset, SDA is released, the counter is 0, no write is pending and the device address is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_i | input | 3 | Device select straps compared with address bits 3..1 |
| wp_i | input | 1 | Write protect; 1 blocks array updates |

## Verification
The hardest state to reach from the pins is the busy window. Its length can only be seen by polling, and only after a stop with buffered data and write protect low. The bench gets there by following every write with an address poll loop, and it expects the first poll to be refused exactly when data was buffered under an open write protect. The page-wrap and array-rollover corners need writes that start near the end of a page and near the top of the array. Directed writes set these up, and sequential reads then cross those boundaries. Seeded random writes and reads follow, checked against a reference array and a counter kept in the bench.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

    // fixed device-type nibble placed above the three strap bits
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WAH,
        ST_WAH_ACK,
        ST_WAL,
        ST_WAL_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_TX,
        ST_MACK
    } link_state_e;

    // bus events seen on the oversampling clock
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] strap);
        return b[7:1] == {DEV_TYPE, strap};
    endfunction

    function automatic logic is_rx_state(input link_state_e s);
        return (s == ST_DEV) || (s == ST_WAH) || (s == ST_WAL) || (s == ST_WDAT);
    endfunction

endpackage

// File: rtl/ee2w_bus_sampler.sv
module ee2w_bus_sampler
    import ee2w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    // stage 0 is the first flop; the top index holds the previous sample
    logic [SYNC_STAGES:0] scl_p;
    logic [SYNC_STAGES:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
            sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_p[SYNC_STAGES-1];
    assign scl_old = scl_p[SYNC_STAGES];
    assign sda_now = sda_p[SYNC_STAGES-1];
    assign sda_old = sda_p[SYNC_STAGES];

    always_comb begin
        ev.rise  = scl_now & ~scl_old;
        ev.fall  = ~scl_now & scl_old;
        ev.start = scl_now & scl_old & sda_old & ~sda_now;
        ev.stop  = scl_now & scl_old & ~sda_old & sda_now;
        ev.sda   = sda_now;
    end

endmodule

// File: rtl/ee2w_array.sv
module ee2w_array #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/ee2w_page_buf.sv
module ee2w_page_buf #(
    parameter int PAGE_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               load,
    input  logic [PAGE_AW-1:0] load_idx,
    input  logic [7:0]         load_data,
    input  logic               go,
    input  logic               drop,
    output logic               active,
    output logic               mem_we,
    output logic [PAGE_AW-1:0] mem_idx,
    output logic [7:0]         mem_data,
    output logic               pending
);

    localparam int DEPTH = 1 << PAGE_AW;

    logic [7:0]         slots [DEPTH];
    logic [DEPTH-1:0]   valid;
    logic [PAGE_AW-1:0] cidx;

    always_ff @(posedge clk) begin
        if (load) slots[load_idx] <= load_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= '0;
            active <= 1'b0;
            cidx   <= '0;
        end else begin
            if (active) begin
                valid[cidx] <= 1'b0;
                cidx        <= cidx + 1'b1;
                if (cidx == {PAGE_AW{1'b1}}) active <= 1'b0;
            end else if (go) begin
                active <= 1'b1;
                cidx   <= '0;
            end
            if (clr || drop) valid <= '0;
            if (load) valid[load_idx] <= 1'b1;
        end
    end

    assign mem_we   = active & valid[cidx];
    assign mem_idx  = cidx;
    assign mem_data = slots[cidx];
    assign pending  = |valid;

endmodule

// File: rtl/ee2w_link.sv
module ee2w_link
    import ee2w_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_AW     = 6,
    parameter int BUSY_CYCLES = 256
) (
    input  logic                      clk,
    input  logic                      rst,
    input  bus_ev_t                   ev,
    input  logic [2:0]                strap,
    input  logic                      wp,
    input  logic [7:0]                rdata,
    input  logic                      pending,
    output logic                      sda_oe,
    output logic [ADDR_W-1:0]         addr_cnt,
    output logic [ADDR_W-PAGE_AW-1:0] page_q,
    output logic                      buf_clr,
    output logic                      buf_load,
    output logic [PAGE_AW-1:0]        buf_idx,
    output logic [7:0]                buf_data,
    output logic                      commit_go,
    output logic                      commit_drop,
    output logic                      busy
);

    localparam int BW = $clog2(BUSY_CYCLES + 1);

    link_state_e       state;
    logic [3:0]        bitcnt;
    logic [7:0]        sh;
    logic [7:0]        hi_q;
    logic [7:0]        tx;
    logic              rw;
    logic              mack;
    logic [BW-1:0]     busy_cnt;
    logic [ADDR_W-1:0] wa_next;
    logic              byte_done;

    assign busy      = busy_cnt != '0;
    assign wa_next   = ADDR_W'({hi_q, sh});
    assign byte_done = ev.fall && (bitcnt == 4'd8);

    assign buf_clr     = !ev.stop && !ev.start && (state == ST_WAL) && byte_done;
    assign buf_load    = !ev.stop && !ev.start && (state == ST_WDAT) && byte_done;
    assign buf_idx     = addr_cnt[PAGE_AW-1:0];
    assign buf_data    = sh;
    assign commit_go   = ev.stop && pending && !busy && !wp;
    assign commit_drop = ev.stop && pending && !busy && wp;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            sh       <= '0;
            hi_q     <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            sda_oe   <= 1'b0;
            addr_cnt <= '0;
            page_q   <= '0;
            busy_cnt <= '0;
        end else begin
            if (busy) busy_cnt <= busy_cnt - 1'b1;

            if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                if (commit_go) busy_cnt <= BW'(BUSY_CYCLES);
            end else if (ev.start) begin
                state  <= ST_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                if (ev.rise && is_rx_state(state) && bitcnt != 4'd8) begin
                    sh     <= {sh[6:0], ev.sda};
                    bitcnt <= bitcnt + 1'b1;
                end
                if (ev.rise && state == ST_MACK) mack <= ~ev.sda;

                if (ev.fall) begin
                    unique case (state)
                        ST_DEV: if (byte_done) begin
                            if (dev_match(sh, strap) && !busy) begin
                                sda_oe <= 1'b1;
                                rw     <= sh[0];
                                state  <= ST_DEV_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        ST_DEV_ACK: begin
                            bitcnt <= rw ? 4'd1 : 4'd0;
                            if (rw) begin
                                tx     <= {rdata[6:0], 1'b0};
                                sda_oe <= ~rdata[7];
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WAH;
                            end
                        end
                        ST_WAH: if (byte_done) begin
                            hi_q   <= sh;
                            sda_oe <= 1'b1;
                            state  <= ST_WAH_ACK;
                        end
                        ST_WAL: if (byte_done) begin
                            addr_cnt <= wa_next;
                            page_q   <= wa_next[ADDR_W-1:PAGE_AW];
                            sda_oe   <= 1'b1;
                            state    <= ST_WAL_ACK;
                        end
                        ST_WDAT: if (byte_done) begin
                            addr_cnt <= {addr_cnt[ADDR_W-1:PAGE_AW],
                                         addr_cnt[PAGE_AW-1:0] + 1'b1};
                            sda_oe   <= 1'b1;
                            state    <= ST_WDAT_ACK;
                        end
                        ST_WAH_ACK, ST_WAL_ACK, ST_WDAT_ACK: begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= (state == ST_WAH_ACK) ? ST_WAL : ST_WDAT;
                        end
                        ST_TX: begin
                            if (bitcnt == 4'd8) begin
                                sda_oe   <= 1'b0;
                                addr_cnt <= addr_cnt + 1'b1;
                                state    <= ST_MACK;
                            end else begin
                                sda_oe <= ~tx[7];
                                tx     <= {tx[6:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                        ST_MACK: begin
                            if (mack) begin
                                tx     <= {rdata[6:0], 1'b0};
                                sda_oe <= ~rdata[7];
                                bitcnt <= 4'd1;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
    import ee2w_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_AW     = 6,
    parameter int BUSY_CYCLES = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);

    bus_ev_t                   ev;
    logic [ADDR_W-1:0]         addr_cnt;
    logic [ADDR_W-PAGE_AW-1:0] page_q;
    logic [7:0]                rdata;
    logic                      buf_clr, buf_load, commit_go, commit_drop;
    logic [PAGE_AW-1:0]        buf_idx, mem_idx;
    logic [7:0]                buf_data, mem_data;
    logic                      mem_we, pending, commit_active, busy;

    ee2w_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    ee2w_link #(
        .ADDR_W      (ADDR_W),
        .PAGE_AW     (PAGE_AW),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_link (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .strap       (strap_i),
        .wp          (wp_i),
        .rdata       (rdata),
        .pending     (pending),
        .sda_oe      (sda_oe),
        .addr_cnt    (addr_cnt),
        .page_q      (page_q),
        .buf_clr     (buf_clr),
        .buf_load    (buf_load),
        .buf_idx     (buf_idx),
        .buf_data    (buf_data),
        .commit_go   (commit_go),
        .commit_drop (commit_drop),
        .busy        (busy)
    );

    ee2w_page_buf #(.PAGE_AW(PAGE_AW)) u_page (
        .clk       (clk),
        .rst       (rst),
        .clr       (buf_clr),
        .load      (buf_load),
        .load_idx  (buf_idx),
        .load_data (buf_data),
        .go        (commit_go),
        .drop      (commit_drop),
        .active    (commit_active),
        .mem_we    (mem_we),
        .mem_idx   (mem_idx),
        .mem_data  (mem_data),
        .pending   (pending)
    );

    ee2w_array #(.AW(ADDR_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr ({page_q, mem_idx}),
        .wdata (mem_data),
        .raddr (addr_cnt),
        .rdata (rdata)
    );

endmodule

// File: rtl/ee2w_slave_chk.sv
module ee2w_slave_chk (
    input logic clk,
    input logic rst,
    input logic ev_fall,
    input logic ev_start,
    input logic ev_stop,
    input logic sda_oe,
    input logic busy,
    input logic mem_we,
    input logic wp
);

    // R2: the data drive moves only after a clock fall, a start or a stop
    a_r2_sda_moves_on_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(ev_fall || ev_start || ev_stop));

    // R2: a start always leaves the data line released
    a_r2_quiet_after_start: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> !sda_oe);

    // R5: array writes happen only inside the busy window
    a_r5_write_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R5: no acknowledge of any kind while busy
    a_r5_silent_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);

    // R6: a busy window opens only from a stop seen with protect low
    a_r6_busy_needs_wp_low: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ev_stop && !wp));

endmodule

bind ee2w_slave ee2w_slave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev_fall  (ev.fall),
    .ev_start (ev.start),
    .ev_stop  (ev.stop),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .mem_we   (mem_we),
    .wp       (wp_i)
);

// File: tb/ee2w_slave_tb.sv
module ee2w_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 12;
    localparam int DEPTH      = 1 << AW;
    localparam int Q          = 5;     // quarter bit in clocks
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ee2w_slave #(.ADDR_W(AW), .PAGE_AW(6), .BUSY_CYCLES(256), .SYNC_STAGES(2)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .strap_i (STRAP),
        .wp_i    (wp)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [7:0] ref_mem [DEPTH];
    bit         ref_known [DEPTH];
    int         ref_addr = 0;

    function automatic logic [7:0] dev_byte(input logic [2:0] s, input logic r);
        return {4'b1010, s, r};
    endfunction

    function automatic int page_slot(input int base, input int k);
        return (base & ~63) | ((base + k) & 63);
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(2 * Q);
        sda_m = 1'b0; tick(2 * Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(2 * Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(2 * Q);
            scl = 1'b0;   tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl = 1'b0; tick(Q);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic wait_ready(input bit exp_busy, input string req);
        bit a = 1'b0;
        int tries = 0;
        while (!a && tries < 40) begin
            bstart();
            send_byte(dev_byte(STRAP, 1'b0), a);
            bstop();
            if (tries == 0) check(req, int'(a), int'(!exp_busy), "first poll acknowledge");
            tries++;
        end
        if (!a) check(req, 0, 1, "device never ready");
    endtask

    task automatic wr(input int addr, input int n, input bit prot,
                      input logic [7:0] hi_extra, input string req);
        bit a;
        logic [7:0] d;
        wp = prot;
        bstart();
        send_byte(dev_byte(STRAP, 1'b0), a);
        check("R1", int'(a), 1, "write address ack");
        send_byte(hi_extra | 8'(addr >> 8), a);
        check("R3", int'(a), 1, "word high ack");
        send_byte(8'(addr), a);
        check("R3", int'(a), 1, "word low ack");
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, a);
            check(req, int'(a), 1, "data byte ack");
            if (!prot) begin
                ref_mem[page_slot(addr, k)]   = d;
                ref_known[page_slot(addr, k)] = 1'b1;
            end
        end
        ref_addr = page_slot(addr, n);
        bstop();
        wp = 1'b0;
        wait_ready(!prot && n > 0, req);
    endtask

    task automatic rd(input bit random, input int addr, input int n, input string req);
        bit a;
        logic [7:0] b;
        bstart();
        if (random) begin
            send_byte(dev_byte(STRAP, 1'b0), a);
            send_byte(8'(addr >> 8), a);
            send_byte(8'(addr), a);
            bstart();
            ref_addr = addr;
        end
        send_byte(dev_byte(STRAP, 1'b1), a);
        check(random ? "R2" : "R7", int'(a), 1, "read address ack");
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            if (ref_known[ref_addr]) check(req, int'(b), int'(ref_mem[ref_addr]), "read data");
            ref_addr = (ref_addr + 1) % DEPTH;
        end
        tick(Q);
        check("R9", int'(sda_oe), 0, "released after master nack");
        bstop();
    endtask

    initial begin
        bit a;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < DEPTH; i++) ref_known[i] = 1'b0;
        tick(10);
        rst = 1'b0;
        tick(4);

        // R11: released line and no busy window out of reset
        check("R11", int'(sda_oe), 0, "sda released after reset");
        wait_ready(1'b0, "R11");

        // R1: another strap pattern gets no acknowledge
        bstart();
        send_byte(dev_byte(STRAP ^ 3'b010, 1'b0), a);
        check("R1", int'(a), 0, "foreign device address");
        bstop();
        bstart();
        send_byte(8'h50 | {4'h0, STRAP, 1'b0}, a);
        check("R1", int'(a), 0, "wrong type nibble");
        bstop();

        // R3/R5: high word bits above the array ignored, busy polled
        wr(12'h123, 6, 1'b0, 8'hF0, "R5");
        rd(1'b1, 12'h123, 4, "R8");
        rd(1'b0, 0, 1, "R7");          // counter persisted at 0x127
        check("R7", ref_addr, 12'h128, "counter after current read");

        // R4: page wrap without touching the next page
        wr(12'h040, 1, 1'b0, 8'h00, "R4");
        wr(12'h03C, 8, 1'b0, 8'h00, "R4");
        rd(1'b1, 12'h000, 4, "R4");
        rd(1'b1, 12'h03C, 5, "R4");    // 0x40 still holds its own byte

        // R6: protected write is acknowledged but changes nothing
        wr(12'h123, 3, 1'b1, 8'h00, "R6");
        rd(1'b1, 12'h123, 3, "R6");

        // R10 + R9: sequential read over the array top
        wr(12'hFFE, 2, 1'b0, 8'h00, "R4");
        rd(1'b1, 12'hFFE, 4, "R10");
        rd(1'b0, 0, 2, "R7");

        // seeded random traffic
        for (int it = 0; it < 16; it++) begin
            int op;
            int ad;
            op = int'($urandom_range(0, 2));
            ad = int'($urandom_range(0, DEPTH - 1));
            if (op == 0)
                wr(ad, int'($urandom_range(1, 16)), ($urandom_range(0, 3) == 0), 8'h00, "R4");
            else if (op == 1)
                rd(1'b0, 0, int'($urandom_range(1, 4)), "R7");
            else
                rd(1'b1, ad, int'($urandom_range(1, 8)), "R9");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule